// File: doc/BRIEF.md
# Command-DMA Request Assembler

This block watches the host register-write path and builds a four-word command-DMA request. A request reaches it in one of two shapes. It can come as one write transaction carrying four data beats, or as four single-beat write transactions, each of which names its slot in the address. When all four words have arrived and every sequencing rule holds, the block presents them together as one 128-bit request with a one-cycle valid strobe.

If the host breaks the sequencing rules, the block raises a one-cycle unsupported-command interrupt and drops whatever it has collected. The rules cover slots that arrive out of order, other commands slipped between the parts, and bursts of the wrong length. Writes to any other command address pass straight through to the downstream command path, unchanged and in the same cycle.

A transaction is framed by `wr_first` on its first beat and `wr_last` on its final beat. A beat with both set is a single-beat transaction. The address is held constant for every beat of a transaction.

Top module: `cmd_seq_assembler`

## Requirements
- R1: A write belongs to the command-DMA class when address bits 31:28 equal 0x0 and bits 27:26 equal 0x2. Every beat of any other write appears on `fwd_*` in the same cycle, with its address, data and framing unchanged. A command-DMA beat never asserts `fwd_valid`.
- R2: Address bits 25:24 of a single-beat command-DMA write give its slot, 0 to 3. Four such writes with slots 0, 1, 2, 3 in that order, with idle cycles allowed between them, produce `req_valid` in the cycle after the slot-3 beat. `req_data` then holds slot 0 in bits 31:0 and slot 3 in bits 127:96.
- R3: A command-DMA transaction of exactly four beats whose address slot field is 0 produces `req_valid` in the cycle after its last beat. `req_data` holds the first beat in bits 31:0 and the fourth beat in bits 127:96.
- R4: A single-beat command-DMA write whose slot is not the next expected one raises `unsup_irq` in the following cycle and discards the collected words. If that write's slot is 0, it becomes slot 0 of a new sequence; otherwise the block waits for a fresh slot 0.
- R5: A foreign write that starts while a multi-transaction sequence is partly collected raises `unsup_irq` and discards that sequence. The foreign write is still forwarded. A foreign write that arrives while nothing is collected raises nothing.
- R6: A command-DMA burst of two, three, or five or more beats, or a burst whose slot field is not 0, raises exactly one `unsup_irq` and produces no request. Beats after the error are ignored up to the end of the transaction.
- R7: A command-DMA burst that starts while a multi-transaction sequence is partly collected raises `unsup_irq` and discards that sequence. The burst itself is then assembled normally.
- R8: `req_valid` is never high for two consecutive cycles and is never high in the same cycle as `unsup_irq`.
- R9: After synchronous reset, `req_valid` and `unsup_irq` are low, `req_data` is zero, and no words are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host write beat present |
| wr_first | input | 1 | Beat is the first of its transaction |
| wr_last | input | 1 | Beat is the last of its transaction |
| wr_addr | input | 32 | Write address, held for the whole transaction |
| wr_data | input | 32 | Write data beat |
| fwd_valid | output | 1 | Forwarded foreign beat present |
| fwd_first | output | 1 | Forwarded first-beat flag |
| fwd_last | output | 1 | Forwarded last-beat flag |
| fwd_addr | output | 32 | Forwarded address |
| fwd_data | output | 32 | Forwarded data |
| req_valid | output | 1 | One-cycle strobe for an assembled request |
| req_data | output | 128 | Assembled request, slot 0 in the low word |
| unsup_irq | output | 1 | One-cycle unsupported-command interrupt |

## Verification
Two pairs of functions can act on the same beat, and both are checked.

The first pair is error reporting and sequence restart. A slot-0 single-beat write made out of order raises the interrupt and is also captured as the first word of a new sequence. The bench sweeps every position in a partial sequence against every wrong slot. It then completes the sequence and checks that the request carries the new slot-0 word.

The second pair is forwarding and interleave detection. A foreign write placed after one, two or three collected slots must appear on the forward port in its own cycle, and the interrupt must follow one cycle later. The bench checks both, then confirms that the next clean sequence assembles correctly.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

    localparam int ADDR_W   = 32;
    localparam int CLS_HI_W = 4;
    localparam int CLS_LO_W = 2;
    localparam int SLOT_LSB = 24;
    localparam int SLOT_W   = 2;

    localparam logic [CLS_HI_W-1:0] CLS_HI_VAL = 4'h0;
    localparam logic [CLS_LO_W-1:0] CLS_LO_VAL = 2'h2;

    typedef enum logic [1:0] {
        MODE_SEQ   = 2'd0,
        MODE_BURST = 2'd1,
        MODE_DRAIN = 2'd2
    } mode_e;

    typedef struct packed {
        logic              is_cmd;
        logic [SLOT_W-1:0] slot;
    } addr_info_t;

    function automatic addr_info_t classify(input logic [ADDR_W-1:0] a);
        addr_info_t r;
        r.is_cmd = (a[31:28] == CLS_HI_VAL) && (a[27:26] == CLS_LO_VAL);
        r.slot   = a[SLOT_LSB +: SLOT_W];
        return r;
    endfunction

endpackage

// File: rtl/cmd_seq_decode.sv
module cmd_seq_decode
    import cmd_seq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output addr_info_t        info
);
    always_comb info = classify(addr);
endmodule

// File: rtl/cmd_seq_store.sv
module cmd_seq_store #(
    parameter int NWORDS = 4,
    parameter int DATA_W = 32,
    localparam int SEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     st_en,
    input  logic [SEL_W-1:0]         st_sel,
    input  logic [DATA_W-1:0]        st_data,
    output logic [NWORDS*DATA_W-1:0] words
);
    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (st_en && (st_sel == SEL_W'(g)))
                word_q <= st_data;
        end
        assign words[g*DATA_W +: DATA_W] = word_q;
    end
endmodule

// File: rtl/cmd_seq_ctrl.sv
module cmd_seq_ctrl
    import cmd_seq_pkg::*;
#(
    parameter int NWORDS = 4,
    localparam int SEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int CNT_W = $clog2(NWORDS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic             wr_first,
    input  logic             wr_last,
    input  addr_info_t       info,
    output logic             st_en,
    output logic [SEL_W-1:0] st_sel,
    output logic             req_valid,
    output logic             unsup
);
    mode_e            mode_q, mode_n;
    logic [CNT_W-1:0] fill_q, fill_n;
    logic             emit, err;
    logic [CNT_W-1:0] slot_w;

    assign slot_w = CNT_W'(info.slot);

    always_comb begin
        mode_n = mode_q;
        fill_n = fill_q;
        st_en  = 1'b0;
        st_sel = '0;
        emit   = 1'b0;
        err    = 1'b0;
        if (wr_valid) begin
            unique case (mode_q)
                MODE_BURST: begin
                    if (fill_q < CNT_W'(NWORDS)) begin
                        st_en  = 1'b1;
                        st_sel = fill_q[SEL_W-1:0];
                        if (wr_last) begin
                            if (fill_q == CNT_W'(NWORDS - 1)) emit = 1'b1;
                            else                              err  = 1'b1;
                            mode_n = MODE_SEQ;
                            fill_n = '0;
                        end else begin
                            fill_n = fill_q + 1'b1;
                        end
                    end else begin
                        err    = 1'b1;
                        fill_n = '0;
                        mode_n = wr_last ? MODE_SEQ : MODE_DRAIN;
                    end
                end
                MODE_DRAIN: begin
                    if (wr_last) mode_n = MODE_SEQ;
                end
                default: begin
                    if (wr_first) begin
                        if (!info.is_cmd) begin
                            if (fill_q != '0) err = 1'b1;
                            fill_n = '0;
                        end else if (!wr_last) begin
                            if (fill_q != '0) err = 1'b1;
                            if (slot_w != '0) begin
                                err    = 1'b1;
                                fill_n = '0;
                                mode_n = MODE_DRAIN;
                            end else begin
                                st_en  = 1'b1;
                                st_sel = '0;
                                fill_n = CNT_W'(1);
                                mode_n = MODE_BURST;
                            end
                        end else if (slot_w == fill_q) begin
                            st_en  = 1'b1;
                            st_sel = info.slot[SEL_W-1:0];
                            if (slot_w == CNT_W'(NWORDS - 1)) begin
                                emit   = 1'b1;
                                fill_n = '0;
                            end else begin
                                fill_n = fill_q + 1'b1;
                            end
                        end else begin
                            err = 1'b1;
                            if (slot_w == '0) begin
                                st_en  = 1'b1;
                                st_sel = '0;
                                fill_n = CNT_W'(1);
                            end else begin
                                fill_n = '0;
                            end
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_SEQ;
            fill_q    <= '0;
            req_valid <= 1'b0;
            unsup     <= 1'b0;
        end else begin
            mode_q    <= mode_n;
            fill_q    <= fill_n;
            req_valid <= emit;
            unsup     <= err;
        end
    end

    // R2: a multi-transaction sequence never holds a full set of words
    assert_seq_fill_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SEQ) |-> (fill_q < CNT_W'(NWORDS)));

    // R8: the request strobe lasts a single cycle
    assert_req_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);

    // R8: a request and an interrupt never share a cycle
    assert_req_no_unsup_R8: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && unsup));

    // R3: a request always follows a beat that closed a transaction
    assert_req_after_last_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $past(wr_valid && wr_last));

    // R5: a foreign write that starts over a partial sequence is reported
    assert_foreign_interleave_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_first && !info.is_cmd && mode_q == MODE_SEQ && fill_q != '0)
        |=> unsup);

    // R6: beats ignored after a bad burst never produce a request
    assert_drain_no_req_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_DRAIN) |=> !req_valid);
endmodule

// File: rtl/cmd_seq_assembler.sv
module cmd_seq_assembler
    import cmd_seq_pkg::*;
#(
    parameter int NWORDS = 4,
    parameter int DATA_W = 32,
    localparam int SEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_valid,
    input  logic                     wr_first,
    input  logic                     wr_last,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic                     fwd_valid,
    output logic                     fwd_first,
    output logic                     fwd_last,
    output logic [ADDR_W-1:0]        fwd_addr,
    output logic [DATA_W-1:0]        fwd_data,
    output logic                     req_valid,
    output logic [NWORDS*DATA_W-1:0] req_data,
    output logic                     unsup_irq
);
    addr_info_t       info;
    logic             st_en;
    logic [SEL_W-1:0] st_sel;

    cmd_seq_decode u_decode (
        .addr (wr_addr),
        .info (info)
    );

    cmd_seq_ctrl #(.NWORDS(NWORDS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_first  (wr_first),
        .wr_last   (wr_last),
        .info      (info),
        .st_en     (st_en),
        .st_sel    (st_sel),
        .req_valid (req_valid),
        .unsup     (unsup_irq)
    );

    cmd_seq_store #(.NWORDS(NWORDS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .st_en   (st_en),
        .st_sel  (st_sel),
        .st_data (wr_data),
        .words   (req_data)
    );

    // Foreign traffic goes downstream untouched
    assign fwd_valid = wr_valid && !info.is_cmd;
    assign fwd_first = wr_first;
    assign fwd_last  = wr_last;
    assign fwd_addr  = wr_addr;
    assign fwd_data  = wr_data;

    // R1: command-DMA beats are never forwarded
    assert_cmd_not_forwarded_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr[31:26] == {CLS_HI_VAL, CLS_LO_VAL}) |-> !fwd_valid);
endmodule

// File: tb/cmd_seq_assembler_bench.sv
`timescale 1ns/1ps
module cmd_seq_assembler_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         wr_valid, wr_first, wr_last;
    logic [31:0]  wr_addr, wr_data;
    logic         fwd_valid, fwd_first, fwd_last;
    logic [31:0]  fwd_addr, fwd_data;
    logic         req_valid, unsup_irq;
    logic [127:0] req_data;

    int n_checks = 0;
    int n_fail   = 0;
    int n_req    = 0;
    int n_unsup  = 0;
    bit both_seen = 1'b0;
    bit done      = 1'b0;
    logic [127:0] last_req;

    localparam logic [31:0] FOREIGN = 32'h1000_0040;

    always #5 clk = ~clk;

    cmd_seq_assembler u_cmd_seq_assembler (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_first(wr_first),
        .wr_last(wr_last), .wr_addr(wr_addr), .wr_data(wr_data),
        .fwd_valid(fwd_valid), .fwd_first(fwd_first), .fwd_last(fwd_last),
        .fwd_addr(fwd_addr), .fwd_data(fwd_data), .req_valid(req_valid),
        .req_data(req_data), .unsup_irq(unsup_irq)
    );

    function automatic logic [31:0] cmd_addr(input int slot);
        return 32'h0800_0000 | (32'(slot) << 24);
    endfunction

    function automatic logic [127:0] pack4(input logic [31:0] s);
        return {s + 32'd3, s + 32'd2, s + 32'd1, s};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_obs();
        n_req = 0;
        n_unsup = 0;
        last_req = '0;
    endtask

    task automatic beat(input logic [31:0] a, input logic [31:0] d,
                        input bit f, input bit l);
        @(negedge clk);
        wr_valid = 1'b1; wr_first = f; wr_last = l; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        if (req_valid) begin n_req++; last_req = req_data; end
        if (unsup_irq) n_unsup++;
        if (req_valid && unsup_irq) both_seen = 1'b1;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_valid = 1'b0; wr_first = 1'b0; wr_last = 1'b0;
        @(posedge clk);
        #1;
        if (req_valid) begin n_req++; last_req = req_data; end
        if (unsup_irq) n_unsup++;
        if (req_valid && unsup_irq) both_seen = 1'b1;
    endtask

    task automatic single(input int slot, input logic [31:0] d);
        beat(cmd_addr(slot), d, 1'b1, 1'b1);
        idle();
    endtask

    task automatic burst(input int nb, input int slot, input logic [31:0] s);
        for (int i = 0; i < nb; i++)
            beat(cmd_addr(slot), s + 32'(i), i == 0, i == nb - 1);
        idle();
    endtask

    task automatic multi(input logic [31:0] s);
        for (int i = 0; i < 4; i++) single(i, s + 32'(i));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        wr_valid = 0; wr_first = 0; wr_last = 0; wr_addr = '0; wr_data = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        chk(!req_valid && !unsup_irq, "R9 outputs idle", {126'b0, req_valid, unsup_irq}, 0);
        chk(req_data == '0, "R9 data cleared", req_data, 0);
        @(negedge clk) rst = 1'b0;

        // R1: forwarding of foreign beats, blocking of command beats
        @(negedge clk);
        wr_valid = 1; wr_first = 1; wr_last = 0; wr_addr = FOREIGN; wr_data = 32'h1234_5678;
        #1;
        chk(fwd_valid && fwd_first && !fwd_last && fwd_addr == FOREIGN && fwd_data == 32'h1234_5678,
            "R1 foreign forwarded", {fwd_valid, fwd_first, fwd_last, fwd_addr, fwd_data},
            {1'b1, 1'b1, 1'b0, FOREIGN, 32'h1234_5678});
        @(negedge clk);
        wr_first = 0; wr_last = 1; wr_data = 32'hCAFE_0001;
        #1;
        chk(fwd_valid && fwd_last && fwd_data == 32'hCAFE_0001, "R1 foreign last beat",
            {fwd_valid, fwd_last, fwd_data}, {1'b1, 1'b1, 32'hCAFE_0001});
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            wr_first = 1; wr_last = 1; wr_addr = cmd_addr(s);
            #1;
            chk(!fwd_valid, "R1 command not forwarded", {127'b0, fwd_valid}, 0);
        end
        @(negedge clk);
        wr_valid = 0; wr_first = 0; wr_last = 0;
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;

        // R2: in-order multi-transaction sequences, several patterns
        for (int p = 0; p < 3; p++) begin
            logic [31:0] s;
            s = 32'hA000_0000 + 32'(p) * 32'h0101_0010;
            clear_obs();
            for (int i = 0; i < 3; i++) single(i, s + 32'(i));
            chk(n_req == 0, "R2 no early request", 128'(n_req), 0);
            beat(cmd_addr(3), s + 32'd3, 1'b1, 1'b1);
            chk(req_valid && req_data == pack4(s), "R2 request after slot 3",
                req_data, pack4(s));
            idle();
            chk(n_req == 1 && n_unsup == 0, "R2 one request no irq",
                {n_req, n_unsup}, {32'd1, 32'd0});
        end

        // R3: four-beat burst
        for (int p = 0; p < 2; p++) begin
            logic [31:0] s;
            s = 32'hB000_0100 + 32'(p) * 32'h40;
            clear_obs();
            burst(4, 0, s);
            chk(n_req == 1 && last_req == pack4(s) && n_unsup == 0, "R3 burst request",
                last_req, pack4(s));
        end

        // R4: sweep of every position against every wrong slot
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) begin
                logic [31:0] s;
                if (k == p) continue;
                s = 32'hC000_0000 + 32'(p * 16 + k) * 32'h100;
                clear_obs();
                for (int i = 0; i < p; i++) single(i, 32'hDEAD_0000 + 32'(i));
                single(k, s);
                chk(n_unsup == 1 && n_req == 0, "R4 wrong slot raises irq",
                    {n_unsup, n_req}, {32'd1, 32'd0});
                clear_obs();
                if (k == 0) begin
                    for (int i = 1; i < 4; i++) single(i, s + 32'(i));
                end else begin
                    multi(s);
                end
                chk(n_req == 1 && n_unsup == 0 && last_req == pack4(s),
                    "R4 sequence after error", last_req, pack4(s));
            end
        end

        // R5: foreign write interleaved at each position
        for (int p = 0; p < 4; p++) begin
            logic [31:0] s;
            s = 32'hD000_0000 + 32'(p) * 32'h10;
            clear_obs();
            for (int i = 0; i < p; i++) single(i, 32'hBAD0_0000 + 32'(i));
            @(negedge clk);
            wr_valid = 1; wr_first = 1; wr_last = 1; wr_addr = FOREIGN; wr_data = s;
            #1;
            chk(fwd_valid && fwd_data == s, "R5 interleaved write forwarded",
                {fwd_valid, fwd_data}, {1'b1, s});
            @(posedge clk);
            #1;
            if (unsup_irq) n_unsup++;
            idle();
            chk(n_unsup == (p == 0 ? 0 : 1), "R5 interleave irq",
                128'(n_unsup), (p == 0 ? 0 : 1));
            clear_obs();
            multi(s);
            chk(n_req == 1 && n_unsup == 0 && last_req == pack4(s), "R5 clean after interleave",
                last_req, pack4(s));
        end

        // R6: wrong burst lengths and bad burst slot
        for (int nb = 2; nb <= 6; nb++) begin
            if (nb == 4) continue;
            clear_obs();
            burst(nb, 0, 32'hE000_0000 + 32'(nb));
            chk(n_unsup == 1 && n_req == 0, "R6 bad burst length",
                {n_unsup, n_req}, {32'd1, 32'd0});
        end
        clear_obs();
        burst(4, 2, 32'hE100_0000);
        chk(n_unsup == 1 && n_req == 0, "R6 burst with nonzero slot",
            {n_unsup, n_req}, {32'd1, 32'd0});
        clear_obs();
        burst(4, 0, 32'hE200_0000);
        chk(n_req == 1 && last_req == pack4(32'hE200_0000) && n_unsup == 0,
            "R6 recovery burst", last_req, pack4(32'hE200_0000));

        // R7: burst over a partial multi-transaction sequence
        for (int p = 1; p < 4; p++) begin
            logic [31:0] s;
            s = 32'hF000_0000 + 32'(p) * 32'h20;
            clear_obs();
            for (int i = 0; i < p; i++) single(i, 32'h5555_0000 + 32'(i));
            burst(4, 0, s);
            chk(n_unsup == 1 && n_req == 1 && last_req == pack4(s), "R7 burst over partial",
                last_req, pack4(s));
        end

        // R8: strobe discipline over all traffic above
        clear_obs();
        burst(4, 0, 32'h7000_0000);
        multi(32'h7100_0000);
        chk(n_req == 2, "R8 one strobe cycle per request", 128'(n_req), 2);
        chk(!both_seen, "R8 request and irq never together", 128'(both_seen), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule